// File: doc/BRIEF.md
# Frame Pixel Streamer

This block is a synthesizable video source. It holds one RGB888 frame in an on-chip RAM whose contents are fixed when the design is elaborated. It plays that frame out once as a timed stream, two horizontally adjacent pixels per clock. A small controller starts by itself when reset is released. It holds a frame-sync output for a start-up interval, then alternates between a quiet line gap and an active line until every row has been sent. A done level then stays up until the next reset.

The stream has no back-pressure. The consumer must take the pixel pair on every cycle in which `pix_valid` is high, and the block cannot be stalled. Lane 0 carries the even pixel of each pair and lane 1 carries the odd pixel. The RAM is read one cycle ahead, so pixel data, `pix_valid`, `frame_sync` and `frame_done` all leave the block from registers in the same cycle.

The stored image is a computed test pattern. The pixel with linear index p (p = IMG_W*row + column) has red = p mod 256, green = (3p+7) mod 256 and blue = 255 − (p mod 256).

Top module: `frame_streamer`

## Requirements
- R1: After `rst_n` is released, exactly two sampled cycles pass with `frame_sync` and `pix_valid` low, and `frame_sync` is high in the third.
- R2: `frame_sync` stays high for exactly STARTUP_CYC+1 consecutive cycles, only once per frame, and it is never high together with `pix_valid`.
- R3: Each active line, the first included, is preceded by exactly GAP_CYC+1 cycles in which both `frame_sync` and `pix_valid` are low.
- R4: Each active line holds `pix_valid` high for exactly IMG_W/2 consecutive cycles.
- R5: Exactly IMG_H active lines are sent, and the row index never reaches IMG_H.
- R6: Beat k of line r carries pixel p = IMG_W*r + 2k on lane 0 and pixel p+1 on lane 1, with the colour values of the pattern above. Lines and beats come out in ascending order.
- R7: Whenever `pix_valid` is low, all six colour outputs are zero.
- R8: `frame_done` is low until the final beat, rises in the same cycle as the final beat, and then stays high. After it rises, no `pix_valid` and no `frame_sync` appear until the next reset.
- R9: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; its release starts the frame |
| frame_sync | output | 1 | High during the start-up interval |
| pix_valid | output | 1 | High on each cycle that carries a pixel pair |
| pix0_r | output | 8 | Even pixel, red |
| pix0_g | output | 8 | Even pixel, green |
| pix0_b | output | 8 | Even pixel, blue |
| pix1_r | output | 8 | Odd pixel, red |
| pix1_g | output | 8 | Odd pixel, green |
| pix1_b | output | 8 | Odd pixel, blue |
| frame_done | output | 1 | Rises on the last beat and stays high until reset |

## Verification
The frame is played out with its default geometry. The stored pattern differs in every channel for each pixel, so a swapped lane, a column skipped or repeated, a row offset or a one-cycle misalignment between RAM data and `pix_valid` each give a mismatch in the scoreboard. Run lengths are measured for the lead-in, the sync pulse, every line gap and every line, which separates off-by-one errors in each counter. The cycles after completion are watched to confirm that the block stays silent and that the done level holds.

// File: rtl/fs_pkg.sv
package fs_pkg;
  localparam int CH_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_VS   = 2'b01,
    ST_GAP  = 2'b10,
    ST_ACT  = 2'b11
  } fs_state_e;

  typedef struct packed {
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } rgb_t;

  // Test pattern stored in the frame RAM at elaboration
  function automatic rgb_t seed_pixel(input int idx);
    rgb_t px;
    int   gv;
    gv   = idx * 3 + 7;
    px.r = CH_W'(idx);
    px.g = CH_W'(gv);
    px.b = ~CH_W'(idx);
    return px;
  endfunction
endpackage

// File: rtl/fs_timing.sv
module fs_timing
  import fs_pkg::*;
#(
  parameter int STARTUP = 100,
  parameter int GAP     = 160
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      line_end,
  input  logic      last_beat,
  output fs_state_e state
);
  localparam int VW = (STARTUP > 0) ? $clog2(STARTUP + 1) : 1;
  localparam int GW = (GAP > 0) ? $clog2(GAP + 1) : 1;

  logic          rst_d;
  logic          start_q;
  logic [VW-1:0] vs_cnt;
  logic [GW-1:0] gap_cnt;
  fs_state_e     nxt;

  // One-cycle start pulse on reset release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_d   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      rst_d   <= 1'b1;
      start_q <= ~rst_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      vs_cnt  <= '0;
      gap_cnt <= '0;
    end else begin
      state   <= nxt;
      vs_cnt  <= (state == ST_VS)  ? vs_cnt + 1'b1  : '0;
      gap_cnt <= (state == ST_GAP) ? gap_cnt + 1'b1 : '0;
    end
  end

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: if (start_q) nxt = ST_VS;
      ST_VS:   if (vs_cnt == VW'(STARTUP)) nxt = ST_GAP;
      ST_GAP:  if (gap_cnt == GW'(GAP)) nxt = ST_ACT;
      ST_ACT: begin
        if (last_beat)     nxt = ST_IDLE;
        else if (line_end) nxt = ST_GAP;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  // R1
  start_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);
  // R2
  vs_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_VS) |-> (vs_cnt <= VW'(STARTUP)));
  // R3
  gap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GAP) |-> (gap_cnt <= GW'(GAP)));
endmodule

// File: rtl/fs_addr.sv
module fs_addr
  import fs_pkg::*;
#(
  parameter int W = 32,
  parameter int H = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  fs_state_e                  state,
  output logic                       line_end,
  output logic                       last_beat,
  output logic [$clog2(W*H/2)-1:0]   pair_addr
);
  localparam int N      = W * H / 2;
  localparam int AW     = $clog2(N);
  localparam int CW     = $clog2(W);
  localparam int RW     = (H > 1) ? $clog2(H) : 1;
  localparam int HALF_W = W / 2;

  logic [CW-1:0] col;
  logic [RW-1:0] row;
  logic [AW-1:0] beat;
  logic          act;

  assign act       = (state == ST_ACT);
  assign line_end  = (col == CW'(W - 2));
  assign last_beat = (beat == AW'(N - 1));
  assign pair_addr = AW'(row) * AW'(HALF_W) + AW'(col >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col  <= '0;
      row  <= '0;
      beat <= '0;
    end else if (act) begin
      if (!last_beat) beat <= beat + 1'b1;
      if (line_end) begin
        col <= '0;
        if (!last_beat) row <= row + 1'b1;
      end else begin
        col <= col + CW'(2);
      end
    end
  end

  // R6
  addr_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> (pair_addr == beat));
  // R5
  row_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> (32'(row) < H));
  // R4
  col_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> (col[0] == 1'b0 && 32'(col) < W));
endmodule

// File: rtl/fs_pixram.sv
module fs_pixram
  import fs_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic              clk,
  input  logic [AW-1:0]     rd_addr,
  output logic [6*CH_W-1:0] rd_pair
);
  logic [6*CH_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = {seed_pixel(2 * i), seed_pixel(2 * i + 1)};
    end
  end

  always_ff @(posedge clk) begin
    rd_pair <= mem[rd_addr];
  end
endmodule

// File: rtl/frame_streamer.sv
module frame_streamer
  import fs_pkg::*;
#(
  parameter int IMG_W       = 32,
  parameter int IMG_H       = 16,
  parameter int STARTUP_CYC = 100,
  parameter int GAP_CYC     = 160
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic       frame_sync,
  output logic       pix_valid,
  output logic [7:0] pix0_r,
  output logic [7:0] pix0_g,
  output logic [7:0] pix0_b,
  output logic [7:0] pix1_r,
  output logic [7:0] pix1_g,
  output logic [7:0] pix1_b,
  output logic       frame_done
);
  localparam int NPAIR = IMG_W * IMG_H / 2;
  localparam int AW    = $clog2(NPAIR);

  fs_state_e         state;
  logic              line_end;
  logic              last_beat;
  logic [AW-1:0]     pair_addr;
  logic [6*CH_W-1:0] rd_pair;
  rgb_t              even_px;
  rgb_t              odd_px;

  fs_timing #(.STARTUP(STARTUP_CYC), .GAP(GAP_CYC)) u_timing (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_end  (line_end),
    .last_beat (last_beat),
    .state     (state)
  );

  fs_addr #(.W(IMG_W), .H(IMG_H)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .line_end  (line_end),
    .last_beat (last_beat),
    .pair_addr (pair_addr)
  );

  fs_pixram #(.DEPTH(NPAIR), .AW(AW)) u_ram (
    .clk     (clk),
    .rd_addr (pair_addr),
    .rd_pair (rd_pair)
  );

  // Control outputs delayed one cycle to line up with RAM read data
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_sync <= 1'b0;
      pix_valid  <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      frame_sync <= (state == ST_VS);
      pix_valid  <= (state == ST_ACT);
      frame_done <= last_beat;
    end
  end

  assign {even_px, odd_px} = rd_pair;
  assign pix0_r = pix_valid ? even_px.r : '0;
  assign pix0_g = pix_valid ? even_px.g : '0;
  assign pix0_b = pix_valid ? even_px.b : '0;
  assign pix1_r = pix_valid ? odd_px.r  : '0;
  assign pix1_g = pix_valid ? odd_px.g  : '0;
  assign pix1_b = pix_valid ? odd_px.b  : '0;

  // R2
  sync_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_sync && pix_valid));
  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> frame_done);
  // R8
  quiet_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frame_done) |-> (!pix_valid && !frame_sync));
endmodule

// File: tb/sim_frame_streamer.sv
module sim_frame_streamer;
  localparam int W = 32;
  localparam int H = 16;
  localparam int S = 100;
  localparam int G = 160;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_sync, pix_valid, frame_done;
  logic [7:0] p0r, p0g, p0b, p1r, p1g, p1b;

  int checks = 0;
  int bad = 0;
  bit mon_en = 1'b0;
  bit finished = 1'b0;
  logic [47:0] exp_q[$];

  always #5 clk = ~clk;

  frame_streamer #(.IMG_W(W), .IMG_H(H), .STARTUP_CYC(S), .GAP_CYC(G)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .pix_valid(pix_valid),
    .pix0_r(p0r), .pix0_g(p0g), .pix0_b(p0b),
    .pix1_r(p1r), .pix1_g(p1g), .pix1_b(p1b), .frame_done(frame_done)
  );

  function automatic logic [23:0] exp_pix(input int p);
    int m;
    m = p % 256;
    return {8'(m), 8'((3 * p + 7) % 256), 8'(255 - m)};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: expected pixel pairs in output order (R6)
  task automatic push_frame();
    for (int r = 0; r < H; r++)
      for (int k = 0; k < W / 2; k++)
        exp_q.push_back({exp_pix(W * r + 2 * k), exp_pix(W * r + 2 * k + 1)});
  endtask

  // Monitor: scoreboard compare and idle-zero check
  always @(negedge clk) begin
    if (mon_en) begin
      if (pix_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 extra beat", 1, 0);
        end else begin
          logic [47:0] e;
          e = exp_q.pop_front();
          check({p0r, p0g, p0b, p1r, p1g, p1b} == e, "R6 pixel pair",
                int'({p0r, p0g, p0b} ^ e[47:24]), int'({p1r, p1g, p1b} ^ e[23:0]));
        end
      end else begin
        check({p0r, p0g, p0b, p1r, p1g, p1b} == 48'd0, "R7 idle pixels zero",
              int'({p0r, p0g, p0b}), 0);
      end
    end
  end

  initial begin
    int n;
    int done_err;
    int after_err;
    repeat (3) @(negedge clk);
    // R9 reset state
    check({frame_sync, pix_valid, frame_done} == 3'b000, "R9 reset controls", int'({frame_sync, pix_valid, frame_done}), 0);
    check({p0r, p0g, p0b, p1r, p1g, p1b} == 48'd0, "R9 reset pixels", int'({p0r, p0g, p0b}), 0);
    push_frame();
    @(negedge clk);
    rst_n = 1'b1;
    mon_en = 1'b1;

    // R1 lead-in
    n = 0;
    @(negedge clk);
    while (!frame_sync && n < 1000) begin
      check(!pix_valid, "R1 no data before sync", 1, 0);
      n++;
      @(negedge clk);
    end
    check(n == 2, "R1 lead-in cycles", n, 2);

    // R2 sync width
    n = 0;
    while (frame_sync && n < 10000) begin n++; @(negedge clk); end
    check(n == S + 1, "R2 sync width", n, S + 1);

    done_err = 0;
    for (int r = 0; r < H; r++) begin
      n = 0;
      while (!pix_valid && !frame_sync && n < 10000) begin
        if (frame_done) done_err++;
        n++;
        @(negedge clk);
      end
      check(n == G + 1, "R3 line gap", n, G + 1);
      check(!frame_sync, "R2 single sync", int'(frame_sync), 0);
      n = 0;
      while (pix_valid && n < 10000) begin
        if (frame_done != ((r == H - 1) && (n == W / 2 - 1))) done_err++;
        n++;
        @(negedge clk);
      end
      check(n == W / 2, "R4 line length", n, W / 2);
    end
    check(done_err == 0, "R8 done timing", done_err, 0);

    // R5 / R8 nothing after the last line
    after_err = 0;
    repeat (400) begin
      if (pix_valid || frame_sync || !frame_done) after_err++;
      @(negedge clk);
    end
    check(after_err == 0, "R5 R8 quiet after frame", after_err, 0);
    check(exp_q.size() == 0, "R6 all beats delivered", exp_q.size(), 0);

    mon_en = 1'b0;
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule